// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous static RAM with a word made of byte lanes. The default is four lanes of eight bits. Every rising clock edge samples a command from the control inputs: an active-low select, an active-low write strobe, active-low per-lane write selects and an address. The address of a read or a write is captured at the edge where the command is seen. The array is then accessed one edge later. A read presents its word after that second edge. A write takes its data from the input bus at that second edge. The bidirectional data bus is split into an input bus, an output bus and a drive-enable flag, so a pad ring can rebuild the tristate pin.

A power-down input puts the array interface to sleep. Entry and exit each take a window of two clock edges. Commands seen while the power-down input is high are dropped. Commands seen during the wake-up window are also dropped, and each one raises a one-cycle error flag. The stored words survive the whole power-down period.

Top module: `lwsram_top`

## Requirements
- R1: A read command (select low, write strobe high) accepted at edge k makes `dq_o` carry the stored word at the captured address after edge k+1. `dq_oe_o` is then high if `oe_n_i` is low.
- R2: A write command (select low, write strobe low) accepted at edge k stores `dq_i` as sampled at edge k+1 into the address captured at edge k.
- R3: Lane i is bits 8i+7..8i and is written only when `bw_n_i[i]` is 0 at the command edge. Every one of the 16 lane combinations is honoured, and unselected lanes keep their old bytes.
- R4: A write command with `bw_n_i` equal to 4'b1111 is an aborted write, and no byte of the array changes.
- R5: A cycle with the select high is a deselect. `dq_oe_o` is low after the edge that follows it.
- R6: `dq_oe_o` is high only while a read result is being presented and `oe_n_i` is low. While `dq_oe_o` is low, `dq_o` reads as zero.
- R7: A read command at the edge right after a write command to the same address returns the newly written lanes merged with the old bytes of the lanes that were not written.
- R8: `pwrdn_o` rises after the second consecutive edge at which `zz_i` is high. Commands seen while `zz_i` is high are ignored.
- R9: The first two edges with `zz_i` low after power-down form the wake window. Commands seen in that window are ignored, and `err_o` is high for one cycle after each such edge if the select was low at it. A command at the third edge is accepted.
- R10: Array contents are retained through power-down and wake-up.
- R11: During reset and after reset, until a read is accepted, `dq_oe_o`, `err_o` and `pwrdn_o` are low, whatever `oe_n_i` says. Reset is asynchronous active-low on `rst_ni` and is released on the second clock edge after it deasserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Active-low chip select |
| we_n_i | input | 1 | Active-low write strobe |
| bw_n_i | input | LANES | Active-low per-lane write selects |
| addr_i | input | ADDR_W | Word address |
| zz_i | input | 1 | Power-down request, active high |
| oe_n_i | input | 1 | Active-low output enable |
| dq_i | input | LANES*LANE_W | Data bus, input half |
| dq_o | output | LANES*LANE_W | Data bus, output half |
| dq_oe_o | output | 1 | Drive enable for the data bus |
| err_o | output | 1 | Command dropped in the wake window |
| pwrdn_o | output | 1 | Array interface is powered down |

## Verification
The bench uses the default build: a 4-bit address (16 words), four 8-bit lanes, and two-edge entry and wake windows. With only 16 words, every address can be written and read back. The lane-select code can also equal the address, so one pass covers all 16 masks, including the aborted write. The two-edge windows keep the power-down and wake sequences short enough to check edge by edge, and a full read-back after wake-up confirms retention for every word.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef enum logic [1:0] {
    MODE_ACT   = 2'd0,
    MODE_ENTER = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_WAKE  = 2'd3
  } lw_mode_e;

endpackage

// File: rtl/lwsram_rst_sync.sv
module lwsram_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/lwsram_sleep.sv
module lwsram_sleep
  import lwsram_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     zz_i,
  output lw_mode_e mode_o,
  output logic     pwrdn_o
);

  localparam int MAX_CYC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ENT_LAST  = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

  lw_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      MODE_ACT, MODE_WAKE: begin
        if (zz_i) begin
          if (ENTRY_CYC <= 1) begin
            mode_d = MODE_SLEEP;
          end else begin
            mode_d = MODE_ENTER;
            cnt_d  = CNT_W'(1);
          end
        end else if (mode_q == MODE_WAKE) begin
          if (cnt_q >= WAKE_LAST) begin
            mode_d = MODE_ACT;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      MODE_ENTER, MODE_SLEEP: begin
        if (zz_i) begin
          if (mode_q == MODE_ENTER) begin
            if (cnt_q >= ENT_LAST) begin
              mode_d = MODE_SLEEP;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end else begin
          if (WAKE_CYC <= 1) begin
            mode_d = MODE_ACT;
          end else begin
            mode_d = MODE_WAKE;
            cnt_d  = CNT_W'(1);
          end
        end
      end
      default: mode_d = MODE_ACT;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ACT;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o  = mode_q;
  assign pwrdn_o = (mode_q == MODE_SLEEP);

  generate
    if (ENTRY_CYC == 2) begin : g_chk_entry
      AST_ENTRY_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwrdn_o) |-> ($past(zz_i) && $past(zz_i, 2))); // R8
    end
    if (WAKE_CYC == 2) begin : g_chk_wake
      AST_WAKE_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_q == MODE_ACT) && ($past(mode_q) != MODE_ACT))
          |-> (!$past(zz_i) && !$past(zz_i, 2))); // R9
    end
  endgenerate

endmodule

// File: rtl/lwsram_decode.sv
module lwsram_decode
  import lwsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce_n_i,
  input  logic             we_n_i,
  input  logic [LANES-1:0] bw_n_i,
  input  logic             zz_i,
  input  lw_mode_e         mode_i,
  output logic             rd_go_o,
  output logic             wr_go_o,
  output logic [LANES-1:0] be_o,
  output logic             drop_o
);

  logic open_w;
  logic sel_w;

  assign open_w  = !zz_i && (mode_i == MODE_ACT);
  assign sel_w   = !ce_n_i;
  assign rd_go_o = open_w && sel_w && we_n_i;
  assign wr_go_o = open_w && sel_w && !we_n_i;
  assign drop_o  = sel_w && !zz_i && (mode_i != MODE_ACT);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_be
      assign be_o[l] = !bw_n_i[l];
    end
  endgenerate

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);

  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem_q [DEPTH];

      always_ff @(posedge clk_i) begin
        if (wr_en_i && wr_be_i[l]) begin
          mem_q[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
        end
      end

      assign rd_data_o[l*LANE_W +: LANE_W] = mem_q[rd_addr_i];
    end
  endgenerate

endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_n_i,
  input  logic                    we_n_i,
  input  logic [LANES-1:0]        bw_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    zz_i,
  input  logic                    oe_n_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o,
  output logic                    err_o,
  output logic                    pwrdn_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic              rst_s_n;
  lw_mode_e          mode_w;
  logic              rd_go, wr_go, drop_w;
  logic [LANES-1:0]  be_w;
  logic [DATA_W-1:0] arr_rd;

  // control pipeline
  logic s1_rd_q, s1_rd_d;
  logic s1_wr_q, s1_wr_d;
  logic rdv_q,   rdv_d;
  logic err_q,   err_d;

  // data pipeline (no reset, clock-enabled)
  logic [ADDR_W-1:0] s1_addr_q;
  logic [LANES-1:0]  s1_be_q;
  logic [DATA_W-1:0] rd_data_q;

  lwsram_rst_sync u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_s_n)
  );

  lwsram_sleep #(
    .ENTRY_CYC(ENTRY_CYC),
    .WAKE_CYC (WAKE_CYC)
  ) u_sleep (
    .clk_i  (clk_i),
    .rst_ni (rst_s_n),
    .zz_i   (zz_i),
    .mode_o (mode_w),
    .pwrdn_o(pwrdn_o)
  );

  lwsram_decode #(
    .LANES(LANES)
  ) u_decode (
    .ce_n_i (ce_n_i),
    .we_n_i (we_n_i),
    .bw_n_i (bw_n_i),
    .zz_i   (zz_i),
    .mode_i (mode_w),
    .rd_go_o(rd_go),
    .wr_go_o(wr_go),
    .be_o   (be_w),
    .drop_o (drop_w)
  );

  lwsram_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_array (
    .clk_i    (clk_i),
    .wr_en_i  (s1_wr_q),
    .wr_addr_i(s1_addr_q),
    .wr_be_i  (s1_be_q),
    .wr_data_i(dq_i),
    .rd_addr_i(s1_addr_q),
    .rd_data_o(arr_rd)
  );

  always_comb begin
    s1_rd_d = rd_go;
    s1_wr_d = wr_go;
    rdv_d   = s1_rd_q;
    err_d   = drop_w;
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s1_rd_q <= 1'b0;
      s1_wr_q <= 1'b0;
      rdv_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      s1_rd_q <= s1_rd_d;
      s1_wr_q <= s1_wr_d;
      rdv_q   <= rdv_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rd_go || wr_go) begin
      s1_addr_q <= addr_i;
      s1_be_q   <= be_w;
    end
    if (s1_rd_q) begin
      rd_data_q <= arr_rd;
    end
  end

  assign dq_oe_o = rdv_q && !oe_n_i;
  assign dq_o    = dq_oe_o ? rd_data_q : '0;
  assign err_o   = err_q;

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    dq_oe_o |-> $past(rd_go, 2)); // R1
  AST_QUIET_WHEN_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (zz_i || (mode_w != MODE_ACT)) |-> !(rd_go || wr_go)); // R8
  AST_ERR_ONLY_WAKE: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    err_o |-> ($past(mode_w) != MODE_ACT)); // R9
  AST_NO_DRIVE_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    oe_n_i |-> (dq_o == '0)); // R6

endmodule

// File: tb/lwsram_top_bench.sv
module lwsram_top_bench;

  logic        clk;
  logic        rst_n;
  logic        ce_n, we_n, zz, oe_n;
  logic [3:0]  bw_n;
  logic [3:0]  addr;
  logic [31:0] din;
  logic [31:0] dq;
  logic        dq_oe, err, pwrdn;

  int n_chk;
  int n_fail;
  bit done;
  logic [31:0] model [16];

  lwsram_top u_lwsram_top (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .ce_n_i (ce_n),
    .we_n_i (we_n),
    .bw_n_i (bw_n),
    .addr_i (addr),
    .zz_i   (zz),
    .oe_n_i (oe_n),
    .dq_i   (din),
    .dq_o   (dq),
    .dq_oe_o(dq_oe),
    .err_o  (err),
    .pwrdn_o(pwrdn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] pat(input int a, input int s);
    return (32'h9E3779B9 * 32'(a + 1)) ^ (32'h01234567 * 32'(s + 1));
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] bwn);
    logic [31:0] r;
    r = old;
    for (int l = 0; l < 4; l++) begin
      if (!bwn[l]) r[8*l +: 8] = d[8*l +: 8];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1;
    we_n = 1'b1;
    bw_n = 4'hF;
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] bwn);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = 4'(a); bw_n = bwn;
    @(negedge clk);
    idle();
    din = d;
    @(negedge clk);
    din = 32'hDEAD_BEEF;
    model[a] = merge(model[a], d, bwn);
  endtask

  task automatic do_read(input int a, input string tag);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; addr = 4'(a);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dq_oe === 1'b1, {tag, " drive"}, {31'd0, dq_oe}, 32'd1);
    chk(dq === model[a], tag, dq, model[a]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; zz = 1'b0; oe_n = 1'b0; din = '0; addr = '0;
    ce_n = 1'b0; we_n = 1'b1; bw_n = 4'hF;
    repeat (4) @(negedge clk);
    // R11: reset state with oe_n low and read attempts on the pins
    chk(dq_oe === 1'b0, "R11 reset drive", {31'd0, dq_oe}, 32'd0);
    chk(err === 1'b0 && pwrdn === 1'b0, "R11 reset flags", {30'd0, err, pwrdn}, 32'd0);
    idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dq_oe === 1'b0, "R11 after reset drive", {31'd0, dq_oe}, 32'd0);

    // R2: fill every word with full writes, R1 read back
    for (int a = 0; a < 16; a++) begin
      model[a] = 32'h0;
      do_write(a, pat(a, 0), 4'h0);
    end
    for (int a = 0; a < 16; a++) do_read(a, "R1 R2 full word");

    // R3/R4: lane mask equals address, all 16 combinations
    for (int a = 0; a < 16; a++) do_write(a, pat(a, 1), 4'(a));
    for (int a = 0; a < 16; a++) begin
      if (a == 15) do_read(a, "R4 abort");
      else         do_read(a, "R3 lane mask");
    end

    // R6: oe_n high suppresses drive, then low re-enables in the same cycle
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; addr = 4'd5;
    @(negedge clk);
    idle();
    oe_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0 && dq === 32'h0, "R6 oe high", dq, 32'h0);
    oe_n = 1'b0;
    #1;
    chk(dq_oe === 1'b1 && dq === model[5], "R6 oe low", dq, model[5]);

    // R5: deselect ends the drive after the following edge
    @(negedge clk);
    chk(dq_oe === 1'b0, "R5 deselect", {31'd0, dq_oe}, 32'd0);

    // R7: read right after a partial write to the same address
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = 4'd9; bw_n = 4'b1010;
    @(negedge clk);
    d = pat(9, 7);
    din = d;
    we_n = 1'b1; bw_n = 4'hF;
    model[9] = merge(model[9], d, 4'b1010);
    @(negedge clk);
    idle();
    @(negedge clk);
    chk(dq_oe === 1'b1 && dq === model[9], "R7 read after write", dq, model[9]);

    // R8: power-down entry; a write attempted while zz high is ignored
    @(negedge clk);
    zz = 1'b1;
    @(negedge clk);
    chk(pwrdn === 1'b0, "R8 one edge", {31'd0, pwrdn}, 32'd0);
    ce_n = 1'b0; we_n = 1'b0; addr = 4'd3; bw_n = 4'h0;
    @(negedge clk);
    chk(pwrdn === 1'b1, "R8 two edges", {31'd0, pwrdn}, 32'd1);
    chk(err === 1'b0, "R8 no err while zz high", {31'd0, err}, 32'd0);
    idle();
    din = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(pwrdn === 1'b1, "R8 held", {31'd0, pwrdn}, 32'd1);

    // R9: wake window drops commands and flags them
    zz = 1'b0;
    ce_n = 1'b0; we_n = 1'b1; addr = 4'd3;
    @(negedge clk);
    chk(err === 1'b1 && pwrdn === 1'b0, "R9 first wake edge", {30'd0, err, pwrdn}, 32'd2);
    we_n = 1'b0; bw_n = 4'h0;
    @(negedge clk);
    chk(err === 1'b1 && dq_oe === 1'b0, "R9 second wake edge", {30'd0, err, dq_oe}, 32'd2);
    we_n = 1'b1; bw_n = 4'hF;
    din = 32'hCAFE_F00D;
    @(negedge clk);
    chk(err === 1'b0, "R9 third edge accepted", {31'd0, err}, 32'd0);
    idle();
    @(negedge clk);
    chk(dq_oe === 1'b1 && dq === model[3], "R9 R10 read after wake", dq, model[3]);

    // R10: every word retained
    for (int a = 0; a < 16; a++) do_read(a, "R10 retention");

    finish_run();
  end

endmodule